// File: doc/BRIEF.md
# First-Word-Fall-Through FIFO

This block is a single-clock FIFO whose read side presents the oldest stored word on a registered output without waiting for a read request. A flag tells the reader that the output register holds a word. The reader consumes the word by pulsing an acknowledge strobe. The block then brings the next word forward on its own. The write side is a conventional push port with back-pressure through a full flag.

Internally, a synchronous-read dual-port array stores the queued words. The array's read register acts as a second holding stage behind the output register. A small prefetch state machine tracks both stages. It launches array reads whenever the stage behind the output can accept a word, so a read already in flight is never lost or repeated. When the FIFO is completely empty, or is about to be, an incoming word goes straight into the output register and skips the array.

Top module: `fwft_fifo`

## Requirements
- R1: A synchronous reset, active low, leaves `data_valid` low, `full` low and `level` at 0, whatever the FIFO held before.
- R2: A word written while `level` is 0 appears on `rd_data` with `data_valid` high right after that same clock edge, with no reader action.
- R3: Words leave in exactly the order they were accepted. No accepted word is lost or repeated, and `level` always equals the number of words in the array, plus the array's read stage, plus the output register.
- R4: When `level` is 3 or more and the head word is taken, `data_valid` stays high on the following cycle, so sustained takes run at one word per clock.
- R5: Taking the head word while it is the only word held, with no write in the same cycle, drops `data_valid` after that edge.
- R6: `data_taken` while `data_valid` is low has no effect. `level` is unchanged, and a word written later is presented normally.
- R7: Capacity is DEPTH+2 words. `full` is high exactly when `level` equals DEPTH+2. A write while `full` is high is discarded and that word never appears at the output.
- R8: A write and a take in the same cycle, while exactly one word is held, leave the new word on `rd_data`, `data_valid` high and `level` at 1 after that edge.
- R9: `level` changes one edge after each access: it rises by one for an accepted write and falls by one for a take made while `data_valid` is high.
- R10: While `data_valid` is high and `data_taken` is low, `rd_data` holds its value and `data_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Push the word on `wr_data` |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No room; pushes are discarded |
| data_valid | output | 1 | `rd_data` holds the oldest word |
| data_taken | input | 1 | Reader has consumed the word on `rd_data` |
| rd_data | output | DATA_W | Head word, driven from a register |
| level | output | clog2(DEPTH+3) | Words held in all stages |

## Verification
The bench builds the FIFO with DEPTH=4 and DATA_W=8. At that size the full capacity of six words is reached after six pushes, and the pointers wrap several times within a short mixed stream. A write blocked by `full` and the drain that follows both come within reach in a handful of cycles. The small depth also makes the state where the head sits alone, with one word queued just behind it, occur often during streaming. That state exercises the bypass path and the prefetch path against each other.

// File: rtl/fwft_fifo_pkg.sv
`timescale 1ns/1ps
// Shared types for the fall-through FIFO.
// Assumes: nothing; pure type declarations.
package fwft_fifo_pkg;

    // Occupancy of the two read stages: bit 0 is the output register,
    // bit 1 is the array's read register.
    typedef enum logic [1:0] {
        OUT_IDLE  = 2'b00,
        OUT_HEAD  = 2'b01,
        OUT_FETCH = 2'b10,
        OUT_BOTH  = 2'b11
    } out_state_e;

endpackage

// File: rtl/fwft_fifo_mem.sv
`timescale 1ns/1ps
// Dual-port storage array with one write port and one registered read port.
// Assumes: read and write addresses may coincide; the read then returns the
// previously stored word. The read register holds its value while re is low.
module fwft_fifo_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] store_q [DEPTH];

    // Store on write, capture the old word on read.
    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
        if (re) rdata <= store_q[raddr];
    end

endmodule

// File: rtl/fwft_fifo_ptr.sv
`timescale 1ns/1ps
// Wrapping address counter for one side of the array.
// Assumes: DEPTH >= 2; wraps from DEPTH-1 to 0, so DEPTH need not be a power of two.
module fwft_fifo_ptr #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    // Step the address on each access, wrapping at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (adv)  ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

endmodule

// File: rtl/fwft_fifo_flags.sv
`timescale 1ns/1ps
// Occupancy bookkeeping: words waiting in the array and words held overall.
// Assumes: push/pop never overflow or underflow the array (the read
// controller guarantees this); full is decoded from the overall count only.
module fwft_fifo_flags #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_push,
    input  logic             mem_pop,
    input  logic             accept,
    input  logic             consume,
    output logic [CNT_W-1:0] mem_cnt,
    output logic [LVL_W-1:0] level,
    output logic             full
);

    localparam int CAP = DEPTH + 2;

    logic [CNT_W-1:0] mem_cnt_n;
    logic [LVL_W-1:0] level_n;

    // Next array count from the array's own push and pop.
    always_comb begin
        mem_cnt_n = mem_cnt;
        if (mem_push && !mem_pop)      mem_cnt_n = mem_cnt + 1'b1;
        else if (!mem_push && mem_pop) mem_cnt_n = mem_cnt - 1'b1;
    end

    // Next overall count from port-level accepts and consumes.
    always_comb begin
        level_n = level;
        if (accept && !consume)      level_n = level + 1'b1;
        else if (!accept && consume) level_n = level - 1'b1;
    end

    // Register both counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cnt <= '0;
            level   <= '0;
        end else begin
            mem_cnt <= mem_cnt_n;
            level   <= level_n;
        end
    end

    assign full = (level == LVL_W'(CAP));

endmodule

// File: rtl/fwft_fifo_rdctl.sv
`timescale 1ns/1ps
// Prefetch controller and output register of the read side.
// Keeps the output register and the array read register filled: an array
// read is launched only when the read register is free or empties this
// cycle, so an in-flight word always has a place to land. An accepted write
// bypasses the array when nothing older is held anywhere and the output
// register is free or being taken.
// Assumes: mem_nonempty reflects words written in earlier cycles only.
module fwft_fifo_rdctl
    import fwft_fifo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_nonempty,
    input  logic              accept,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              taken,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_re,
    output logic              mem_push,
    output logic              consume,
    output logic              rdq_full,
    output logic              data_valid,
    output logic [DATA_W-1:0] rd_data
);

    out_state_e state;
    logic out_free, q_move, bypass, ov_n, q_n;

    assign data_valid = state[0];
    assign rdq_full   = state[1];

    // Decide this cycle's moves between array, read register and output.
    always_comb begin
        consume  = taken && state[0];
        out_free = !state[0] || consume;
        q_move   = state[1] && out_free;
        mem_re   = mem_nonempty && (!state[1] || q_move);
        bypass   = accept && out_free && !state[1] && !mem_nonempty;
        mem_push = accept && !bypass;
        ov_n     = q_move || bypass || (state[0] && !consume);
        q_n      = mem_re || (state[1] && !q_move);
    end

    // Advance the two-stage occupancy state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= OUT_IDLE;
        else        state <= out_state_e'({q_n, ov_n});
    end

    // Load the output register from the read register or the bypass path.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (q_move) rd_data <= mem_rdata;
        else if (bypass) rd_data <= wr_data;
    end

endmodule

// File: rtl/fwft_fifo.sv
`timescale 1ns/1ps
// Single-clock FIFO with a fall-through read port: the head word sits in a
// register flagged by data_valid and is released by data_taken.
// Assumes: DEPTH >= 2; capacity is DEPTH array words plus two read stages.
module fwft_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    output logic                       full,
    output logic                       data_valid,
    input  logic                       data_taken,
    output logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH+3)-1:0] level
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int LVL_W  = $clog2(DEPTH + 3);

    logic              accept, mem_push, mem_re, consume, rdq_full;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [CNT_W-1:0]  mem_cnt;
    logic [DATA_W-1:0] mem_rdata;

    assign accept = wr_en && !full;

    fwft_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .we(mem_push), .waddr(waddr), .wdata(wr_data),
        .re(mem_re), .raddr(raddr), .rdata(mem_rdata)
    );

    fwft_fifo_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wptr (
        .clk(clk), .rst_n(rst_n), .adv(mem_push), .ptr(waddr)
    );

    fwft_fifo_ptr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rptr (
        .clk(clk), .rst_n(rst_n), .adv(mem_re), .ptr(raddr)
    );

    fwft_fifo_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .mem_push(mem_push), .mem_pop(mem_re),
        .accept(accept), .consume(consume), .mem_cnt(mem_cnt),
        .level(level), .full(full)
    );

    fwft_fifo_rdctl #(.DATA_W(DATA_W)) u_rdctl (
        .clk(clk), .rst_n(rst_n), .mem_nonempty(mem_cnt != '0),
        .accept(accept), .wr_data(wr_data), .taken(data_taken),
        .mem_rdata(mem_rdata), .mem_re(mem_re), .mem_push(mem_push),
        .consume(consume), .rdq_full(rdq_full), .data_valid(data_valid),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/fwft_fifo_chk.sv
`timescale 1ns/1ps
// Property checker for the fall-through FIFO, attached by bind.
// Assumes: connected to the top's ports plus its array count and read-stage flag.
module fwft_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5,
    parameter int LVL_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              full,
    input logic              data_valid,
    input logic              data_taken,
    input logic [DATA_W-1:0] rd_data,
    input logic [LVL_W-1:0]  level,
    input logic [CNT_W-1:0]  mem_cnt,
    input logic              rdq_full
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!data_valid && !full && level == '0));

    a_r2_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && wr_en) |=> (data_valid && rd_data == $past(wr_data)));

    a_r3_stage_sum: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) == int'(mem_cnt) + int'(rdq_full) + int'(data_valid));

    a_r4_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && data_taken && level >= LVL_W'(3)) |=> data_valid);

    a_r5_last_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && data_taken && level == LVL_W'(1) && !wr_en) |=> !data_valid);

    a_r6_idle_take: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_valid && data_taken && !wr_en) |=> $stable(level));

    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !data_taken) |=> $stable(level));

    a_r8_swap_single: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && data_taken && wr_en && !full && level == LVL_W'(1))
        |=> (data_valid && level == LVL_W'(1) && rd_data == $past(wr_data)));

    a_r9_level_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || data_taken) |=> int'(level) == int'($past(level))
            + int'($past(wr_en && !full)) - int'($past(data_taken && data_valid)));

    a_r10_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_valid && !data_taken) |=> (data_valid && $stable(rd_data)));

endmodule

bind fwft_fifo fwft_fifo_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .data_valid(data_valid), .data_taken(data_taken), .rd_data(rd_data),
    .level(level), .mem_cnt(mem_cnt), .rdq_full(rdq_full)
);

// File: tb/fwft_fifo_test.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results
// against a queue model of the requirements.
module fwft_fifo_test;

    localparam int DW  = 8;
    localparam int DEP = 4;
    localparam int CAP = DEP + 2;
    localparam int LW  = $clog2(DEP + 3);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          data_taken = 1'b0;
    logic          full, data_valid;
    logic [DW-1:0] rd_data;
    logic [LW-1:0] level;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] model_q[$];

    always #4 clk = ~clk;

    fwft_fifo #(.DATA_W(DW), .DEPTH(DEP)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .data_valid(data_valid), .data_taken(data_taken),
        .rd_data(rd_data), .level(level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock with the given inputs; updates the model and checks order and level.
    task automatic cycle(input logic w, input logic [DW-1:0] d, input logic t);
        logic          pre_full, pre_valid;
        logic [DW-1:0] pre_data, exp;
        int            pre_level;
        pre_full  = full;
        pre_valid = data_valid;
        pre_data  = rd_data;
        pre_level = int'(level);
        wr_en = w; wr_data = d; data_taken = t;
        @(posedge clk); #1;
        if (t && pre_valid) begin
            exp = model_q.pop_front();
            check(pre_data == exp, "R3 order", pre_data, exp);
            if (pre_level >= 3)
                check(data_valid == 1'b1, "R4 valid kept", data_valid, 1);
        end
        if (w && !pre_full) model_q.push_back(d);
        check(int'(level) == model_q.size(), "R9 level", level, model_q.size());
        wr_en = 1'b0; data_taken = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && model_q.size() != 0; i++) cycle(1'b0, '0, 1'b1);
        check(data_valid == 1'b0, "R3 drained", data_valid, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        model_q.delete();
        check(data_valid == 1'b0, "R1 valid", data_valid, 0);
        check(full == 1'b0, "R1 full", full, 0);
        check(level == '0, "R1 level", level, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_first_word();
        cycle(1'b1, 8'hA5, 1'b0);
        check(data_valid == 1'b1, "R2 valid", data_valid, 1);
        check(rd_data == 8'hA5, "R2 data", rd_data, 8'hA5);
        cycle(1'b0, '0, 1'b1);
        check(data_valid == 1'b0, "R5 valid falls", data_valid, 0);
    endtask

    task automatic t_idle_take();
        repeat (3) cycle(1'b0, '0, 1'b1);
        check(data_valid == 1'b0 && level == '0, "R6 idle take", level, 0);
        cycle(1'b1, 8'h3C, 1'b1);
        check(data_valid == 1'b1, "R6 valid after", data_valid, 1);
        check(rd_data == 8'h3C, "R6 data after", rd_data, 8'h3C);
        drain();
    endtask

    task automatic t_hold();
        cycle(1'b1, 8'h51, 1'b0);
        cycle(1'b1, 8'h52, 1'b0);
        for (int i = 0; i < 4; i++) begin
            cycle(1'b0, '0, 1'b0);
            check(data_valid == 1'b1 && rd_data == 8'h51, "R10 hold", rd_data, 8'h51);
        end
        drain();
    endtask

    task automatic t_swap_single();
        cycle(1'b1, 8'h11, 1'b0);
        cycle(1'b1, 8'h22, 1'b1);
        check(data_valid == 1'b1, "R8 valid", data_valid, 1);
        check(rd_data == 8'h22, "R8 data", rd_data, 8'h22);
        check(level == LW'(1), "R8 level", level, 1);
        drain();
    endtask

    task automatic t_fill();
        for (int i = 0; i < CAP; i++) cycle(1'b1, 8'h60 + 8'(i), 1'b0);
        check(full == 1'b1, "R7 full", full, 1);
        check(int'(level) == CAP, "R7 level", level, CAP);
        cycle(1'b1, 8'hEE, 1'b0);
        check(int'(level) == CAP, "R7 drop", level, CAP);
        drain();
    endtask

    task automatic t_reset_busy();
        for (int i = 0; i < 3; i++) cycle(1'b1, 8'h70 + 8'(i), 1'b0);
        t_reset();
        cycle(1'b1, 8'h99, 1'b0);
        check(rd_data == 8'h99 && data_valid, "R1 contents cleared", rd_data, 8'h99);
        drain();
    endtask

    task automatic t_stream();
        for (int i = 0; i < 160; i++) begin
            logic w, t;
            w = (i < 80) ? (i % 4 != 3) : (i % 3 == 0);
            t = (i < 80) ? (i % 3 == 0) : 1'b1;
            cycle(w, 8'(i * 7 + 3), t);
        end
        drain();
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_first_word();
        t_idle_take();
        t_hold();
        t_swap_single();
        t_fill();
        t_stream();
        t_reset_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule